// File: doc/BRIEF.md
# Two-bit data-strobe serializer

This block sends a data-strobe pair of serial lines from parallel bit pairs. Once per rising edge of a slow write clock, logic upstream hands it two data bits and two strobe bits. The block sends them out one bit at a time on a transmit clock that runs at exactly twice the write-clock rate. Bit 0 goes first and bit 1 goes second. The two clocks come from one source, but the phase between them is unknown. The block therefore locks its read side to the write side once after reset, and from then on alternates between two holding slots without further handshaking.

A single active-low reset feeds separate synchronizers in both clock domains. Upstream logic must hold reset low for at least three write-clock cycles. It must then wait three full write-clock cycles after release before presenting real data. Pairs presented earlier are dropped, and the serial lines stay at 0 until the first valid pair goes out.

A remote-loopback control drives the serial lines from the receive-side serial inputs instead of from the parallel pair. This path works whether or not reset is asserted. An output-enable control produces a registered drive-enable for the line pad; when it is low, the pad holds the lines in high impedance.

Top module: `ds_pair_serializer`

## Requirements
- R1: Within each pair, the bit at index 0 is sent before the bit at index 1. This order holds on both the data line and the strobe line.
- R2: The data bit and the strobe bit of the same index leave on the same rising edge of the transmit clock. Both come from registers, so the two lines change only at that edge.
- R3: Serialization is correct for every fixed phase offset between the two clocks, given that the transmit clock is exactly twice the write-clock frequency.
- R4: Reset is released just after a falling write-clock edge. The pairs captured on the first three rising write-clock edges after release are discarded. The first pair sent is the one captured on the fourth rising edge, and both lines read 0 until its first bit appears.
- R5: The first bit of that first pair appears on the lines no later than 1.5 transmit-clock periods after the fourth rising write-clock edge, and never before it.
- R6: From then on, every captured pair is sent exactly once and in capture order. Each pair takes two consecutive transmit-clock cycles, and there are no gaps, skips or repeats.
- R7: With remote loopback off, both lines are 0 from the first rising transmit-clock edge after reset goes low. They stay 0 for as long as reset stays low.
- R8: With remote loopback on, each rising transmit-clock edge loads the lines with the receive-side data and strobe inputs. This applies with reset high or low.
- R9: The drive-enable output equals the output-enable input as sampled at the previous rising transmit-clock edge. A value of 0 tells the pad to hold both lines in high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Slow write clock; captures one parallel pair per rising edge |
| tx_clk | input | 1 | Transmit clock at twice the write-clock rate, same source |
| rst_n | input | 1 | Active-low asynchronous reset, synchronized in each domain |
| par_d | input | 2 | Parallel data pair; bit 0 is sent first |
| par_s | input | 2 | Parallel strobe pair; bit 0 is sent first |
| tx_en | input | 1 | Output enable for the serial lines |
| rmt_lb | input | 1 | Remote loopback: 1 sends the receive-side inputs out |
| rx_d | input | 1 | Receive-side serial data input |
| rx_s | input | 1 | Receive-side serial strobe input |
| ser_d | output | 1 | Serial data line |
| ser_s | output | 1 | Serial strobe line |
| ser_en | output | 1 | Drive-enable for the line pad; 0 means high impedance |

## Verification
The bench resets the block again at each of eight write-clock phase offsets. The set includes offsets where the rising edges of the two clocks coincide, which is where a read side that picks the wrong slot after locking would send each pair twice, or send stale data. At each offset the bench presents random junk before the three-cycle window and then a marker pair. A design that lets an early pair through, or that locks one write cycle late, shows up as nonzero bits before the marker or as a marker outside the latency window. After the marker, the bench compares every bit of a random stream on both lines. Any bit-order swap, phase drift or slot mix-up appears as a mismatch. It also checks that loopback follows the receive inputs both in reset and in normal operation, and that the lines go to 0 after reset.

// File: rtl/dss_pkg.sv
package dss_pkg;

  // bits per parallel word on each line; the 2:1 clock ratio fixes this
  localparam int unsigned LANE_BITS = 2;
  // ping-pong depth between the clock domains
  localparam int unsigned SLOTS = 2;

  typedef struct packed {
    logic [LANE_BITS-1:0] strb;
    logic [LANE_BITS-1:0] data;
  } pair_t;

  typedef struct packed {
    logic strb;
    logic data;
  } lane_t;

  // Slot to read first when the fast side sees its first pointer toggle
  // through a chain of 'stages' flops. The toggle comes from a write at T.
  // The first read lands in (T+stages, T+stages+1] transmit cycles. The
  // newest slot that is safe to read was written floor(stages/2) write
  // cycles after T. An odd count of write cycles lands in the slot the
  // seen pointer names, an even count in the other slot.
  function automatic logic first_slot(input logic seen_ptr, input int unsigned stages);
    int unsigned writes_after;
    writes_after = stages / 2;
    return (writes_after % 2 == 1) ? seen_ptr : ~seen_ptr;
  endfunction

  // pick the bit of one index from both lines of a pair
  function automatic lane_t lane_of(input pair_t p, input logic phase);
    lane_t l;
    l.data = p.data[phase];
    l.strb = p.strb[phase];
    return l;
  endfunction

endpackage

// File: rtl/dss_rst_sync.sv
module dss_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain;

  // asserts at once, releases after STAGES rising edges
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain[STAGES-1];

endmodule

// File: rtl/dss_wr_pingpong.sv
module dss_wr_pingpong
  import dss_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                  wr_clk,
  input  logic                  arst_n,
  input  pair_t                 pair_i,
  output pair_t [SLOTS-1:0]     slot_o,
  output logic                  wptr_o
);

  logic wr_rst_n;
  logic wptr;

  dss_rst_sync #(.STAGES(RST_STAGES)) u_wr_rst (
    .clk    (wr_clk),
    .arst_n (arst_n),
    .srst_n (wr_rst_n)
  );

  // write pointer flips on every write-clock edge once out of reset
  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) wptr <= 1'b0;
    else           wptr <= ~wptr;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    localparam logic SLOT_ID = 1'(g);
    pair_t held_q;
    always_ff @(posedge wr_clk) begin
      if (wr_rst_n && (wptr == SLOT_ID)) held_q <= pair_i;
    end
    assign slot_o[g] = held_q;
  end

  assign wptr_o = wptr;

  // R6
  wptr_flips_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $past(wr_rst_n) |-> (wptr != $past(wptr)));

endmodule

// File: rtl/dss_tx_align.sv
module dss_tx_align
  import dss_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic tx_clk,
  input  logic tx_rst_n,
  input  logic wptr_async,
  output logic rd_valid,
  output logic rd_slot,
  output logic rd_phase
);

  localparam int unsigned CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] ptr_sync;
  logic             ptr_seen;
  logic             ptr_prev;
  logic             toggle_seen;
  logic             align_evt;
  logic             lock_slot;
  logic             locked;
  logic             rptr;
  logic             ph;

  // synchronizer plus one extra flop to spot the toggle
  always_ff @(posedge tx_clk or negedge tx_rst_n) begin
    if (!tx_rst_n) ptr_sync <= '0;
    else           ptr_sync <= {ptr_sync[CHAIN-2:0], wptr_async};
  end

  assign ptr_seen    = ptr_sync[SYNC_STAGES-1];
  assign ptr_prev    = ptr_sync[SYNC_STAGES];
  assign toggle_seen = ptr_seen ^ ptr_prev;
  assign align_evt   = toggle_seen & ~locked;
  assign lock_slot   = first_slot(ptr_seen, SYNC_STAGES);

  // lock once; afterwards free-run, two bits per slot
  always_ff @(posedge tx_clk or negedge tx_rst_n) begin
    if (!tx_rst_n) begin
      locked <= 1'b0;
      rptr   <= 1'b0;
      ph     <= 1'b0;
    end else if (align_evt) begin
      locked <= 1'b1;
      rptr   <= lock_slot;
      ph     <= 1'b1;
    end else if (locked) begin
      ph <= ~ph;
      if (ph) rptr <= ~rptr;
    end
  end

  assign rd_valid = locked | align_evt;
  assign rd_slot  = locked ? rptr : lock_slot;
  assign rd_phase = locked ? ph : 1'b0;

  // R6
  phase_alternates_chk: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    locked |=> (rd_phase != $past(rd_phase)));

  // R6
  slot_advance_chk: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    (locked && rd_phase) |=> (rd_slot != $past(rd_slot)));

  // R6
  slot_hold_chk: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    (locked && !rd_phase) |=> (rd_slot == $past(rd_slot)));

  // R3
  lock_keeps_chk: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    locked |=> locked);

  // R3
  writer_phase_chk: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    (locked && toggle_seen) |-> !rd_phase);

endmodule

// File: rtl/dss_tx_outstage.sv
module dss_tx_outstage
  import dss_pkg::*;
(
  input  logic  tx_clk,
  input  logic  tx_rst_n,
  input  logic  rd_valid,
  input  lane_t lane_i,
  input  logic  rmt_lb,
  input  logic  rx_d,
  input  logic  rx_s,
  input  logic  tx_en,
  output logic  ser_d,
  output logic  ser_s,
  output logic  ser_en
);

  lane_t line_nxt;
  lane_t line_q;
  logic  en_q;

  always_comb begin
    if (rmt_lb)                     line_nxt = '{strb: rx_s, data: rx_d};
    else if (tx_rst_n && rd_valid)  line_nxt = lane_i;
    else                            line_nxt = '0;
  end

  // both lines and the enable leave from the same edge
  always_ff @(posedge tx_clk) begin
    line_q <= line_nxt;
    en_q   <= tx_en;
  end

  assign ser_d  = line_q.data;
  assign ser_s  = line_q.strb;
  assign ser_en = en_q;

  // R8
  loop_follow_chk: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    rmt_lb |=> ((ser_d == $past(rx_d)) && (ser_s == $past(rx_s))));

  // R7
  idle_zero_chk: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    (!rmt_lb && !rd_valid) |=> (!ser_d && !ser_s));

  // R9
  enable_follow_chk: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    $past(tx_rst_n) |-> (ser_en == $past(tx_en)));

endmodule

// File: rtl/ds_pair_serializer.sv
module ds_pair_serializer
  import dss_pkg::*;
#(
  parameter int unsigned RST_STAGES  = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       wr_clk,
  input  logic       tx_clk,
  input  logic       rst_n,
  input  logic [1:0] par_d,
  input  logic [1:0] par_s,
  input  logic       tx_en,
  input  logic       rmt_lb,
  input  logic       rx_d,
  input  logic       rx_s,
  output logic       ser_d,
  output logic       ser_s,
  output logic       ser_en
);

  pair_t              par_pair;
  pair_t [SLOTS-1:0]  slots;
  logic               wptr;
  logic               tx_rst_n;
  logic               rd_valid;
  logic               rd_slot;
  logic               rd_phase;
  lane_t              cur_lane;

  assign par_pair = '{strb: par_s, data: par_d};

  dss_wr_pingpong #(.RST_STAGES(RST_STAGES)) u_wr (
    .wr_clk (wr_clk),
    .arst_n (rst_n),
    .pair_i (par_pair),
    .slot_o (slots),
    .wptr_o (wptr)
  );

  dss_rst_sync #(.STAGES(RST_STAGES)) u_tx_rst (
    .clk    (tx_clk),
    .arst_n (rst_n),
    .srst_n (tx_rst_n)
  );

  dss_tx_align #(.SYNC_STAGES(SYNC_STAGES)) u_align (
    .tx_clk     (tx_clk),
    .tx_rst_n   (tx_rst_n),
    .wptr_async (wptr),
    .rd_valid   (rd_valid),
    .rd_slot    (rd_slot),
    .rd_phase   (rd_phase)
  );

  assign cur_lane = lane_of(slots[rd_slot], rd_phase);

  dss_tx_outstage u_out (
    .tx_clk   (tx_clk),
    .tx_rst_n (tx_rst_n),
    .rd_valid (rd_valid),
    .lane_i   (cur_lane),
    .rmt_lb   (rmt_lb),
    .rx_d     (rx_d),
    .rx_s     (rx_s),
    .tx_en    (tx_en),
    .ser_d    (ser_d),
    .ser_s    (ser_s),
    .ser_en   (ser_en)
  );

endmodule

// File: tb/ds_pair_serializer_bench.sv
module ds_pair_serializer_bench;

  localparam int NPAIRS = 24;

  logic       wr_clk = 1'b0;
  logic       tx_clk = 1'b0;
  logic       rst_n  = 1'b0;
  logic [1:0] par_d  = '0;
  logic [1:0] par_s  = '0;
  logic       tx_en  = 1'b1;
  logic       rmt_lb = 1'b0;
  logic       rx_d   = 1'b0;
  logic       rx_s   = 1'b0;
  logic       ser_d;
  logic       ser_s;
  logic       ser_en;

  int      checks = 0;
  int      fails  = 0;
  bit      done   = 0;
  int      wr_shift = 0;
  realtime edge4_t;
  logic [3:0] expq[$];

  ds_pair_serializer u_ds_pair_serializer (
    .wr_clk (wr_clk), .tx_clk (tx_clk), .rst_n (rst_n),
    .par_d (par_d), .par_s (par_s), .tx_en (tx_en), .rmt_lb (rmt_lb),
    .rx_d (rx_d), .rx_s (rx_s),
    .ser_d (ser_d), .ser_s (ser_s), .ser_en (ser_en)
  );

  // transmit clock: period 20 units (50 MHz at 1 ns)
  always #10 tx_clk = ~tx_clk;

  // write clock at half rate; wr_shift delays one period to move the phase
  always begin
    if (wr_shift != 0) begin
      #(wr_shift);
      wr_shift = 0;
    end
    wr_clk = 1'b1;
    #20;
    wr_clk = 1'b0;
    #20;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive_pairs();
    for (int c = 1; c <= 3 + NPAIRS + 4; c++) begin
      @(posedge wr_clk);
      if (c == 4) edge4_t = $realtime;
      @(negedge wr_clk);
      if (c < 3) begin
        {par_s, par_d} = 4'($urandom);            // junk, must be dropped
      end else if (c == 3) begin
        par_d = 2'b11; par_s = 2'b10;             // marker, captured on edge 4
      end else begin
        logic [3:0] v;
        v = 4'($urandom);
        par_d = v[1:0]; par_s = v[3:2];
        expq.push_back(v);
      end
    end
  endtask

  task automatic watch_stream(input int phase);
    int      waited = 0;
    bit      zeros_ok = 1;
    bit      found = 0;
    realtime mt;
    while (!found && waited < 40) begin
      @(negedge tx_clk);
      waited++;
      if (ser_d) found = 1;
      else if (ser_s) zeros_ok = 0;
    end
    check(zeros_ok, "R4", $sformatf("lines zero before first pair, phase %0d", phase),
          {3'b0, ~zeros_ok}, 4'h0);
    check(found, "R4", $sformatf("first pair seen, phase %0d", phase), {3'b0, found}, 4'h1);
    if (!found) return;
    mt = $realtime;
    check((mt > edge4_t) && (mt - edge4_t <= 30.0), "R5",
          $sformatf("first-bit latency, phase %0d", phase),
          4'(int'(mt - edge4_t) / 10), 4'h3);
    // R1: bit 0 of marker has strobe 0, bit 1 has strobe 1
    check(ser_s == 1'b0, "R1", "marker even bit strobe", {3'b0, ser_s}, 4'h0);
    @(negedge tx_clk);
    check({ser_s, ser_d} == 2'b11, "R1", "marker odd bit", {2'b0, ser_s, ser_d}, 4'h3);
    for (int p = 0; p < NPAIRS; p++) begin
      for (int b = 0; b < 2; b++) begin
        logic [1:0] ex;
        @(negedge tx_clk);
        ex = {expq[p][2+b], expq[p][b]};
        // R6 stream order, R2 lines together, R3 at this phase
        check({ser_s, ser_d} == ex, "R6",
              $sformatf("pair %0d bit %0d (R2 R3 phase %0d)", p, b, phase),
              {2'b0, ser_s, ser_d}, {2'b0, ex});
      end
    end
  endtask

  task automatic run_phase(input int shift, input int phase);
    rst_n = 1'b0; rmt_lb = 1'b0; tx_en = 1'b1;
    {par_s, par_d} = 4'($urandom);
    repeat (2) @(posedge wr_clk);
    wr_shift = shift;
    repeat (4) @(posedge wr_clk);
    @(negedge tx_clk);
    check({ser_s, ser_d} == 2'b00, "R7", "lines zero in reset", {2'b0, ser_s, ser_d}, 4'h0);
    check(ser_en == 1'b1, "R9", "enable high", {3'b0, ser_en}, 4'h1);
    @(negedge wr_clk);
    rst_n = 1'b1;
    expq.delete();
    fork
      drive_pairs();
      watch_stream(phase);
    join
    // R8 loopback while running
    @(negedge tx_clk);
    rmt_lb = 1'b1;
    {rx_s, rx_d} = 2'($urandom);
    for (int k = 0; k < 6; k++) begin
      logic [1:0] prev;
      prev = {rx_s, rx_d};
      @(negedge tx_clk);
      check({ser_s, ser_d} == prev, "R8", "loopback running", {2'b0, ser_s, ser_d}, {2'b0, prev});
      {rx_s, rx_d} = 2'($urandom);
    end
    // R7 reset mid-stream with loopback off
    rmt_lb = 1'b0;
    @(negedge tx_clk);
    rst_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge tx_clk);
      check({ser_s, ser_d} == 2'b00, "R7", "zero after reset", {2'b0, ser_s, ser_d}, 4'h0);
    end
    // R8 loopback during reset
    rmt_lb = 1'b1;
    {rx_s, rx_d} = 2'($urandom);
    for (int k = 0; k < 4; k++) begin
      logic [1:0] prev;
      prev = {rx_s, rx_d};
      @(negedge tx_clk);
      check({ser_s, ser_d} == prev, "R8", "loopback in reset", {2'b0, ser_s, ser_d}, {2'b0, prev});
      {rx_s, rx_d} = ~prev;
    end
    rmt_lb = 1'b0;
    @(negedge tx_clk);
    check({ser_s, ser_d} == 2'b00, "R7", "zero after loopback off", {2'b0, ser_s, ser_d}, 4'h0);
    // R9 enable
    tx_en = 1'b0;
    @(negedge tx_clk);
    check(ser_en == 1'b0, "R9", "enable low", {3'b0, ser_en}, 4'h0);
    tx_en = 1'b1;
    @(negedge tx_clk);
    check(ser_en == 1'b1, "R9", "enable back high", {3'b0, ser_en}, 4'h1);
  endtask

  initial begin
    for (int ph = 0; ph < 8; ph++) begin
      run_phase((ph == 0) ? 0 : 5, ph);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule